// File: doc/BRIEF.md
# Periodic Pulse Generator

This block drives a set of periodic output pulses that stay in step with a free-running nanosecond time counter. Each channel holds a 32-bit interval value and a down-counter that loses one reference period on every timer tick. When the down-counter would underflow, the channel starts a pulse, raises a one-clock event strobe and reloads the interval. One prescale value, shared by all channels, sets the pulse width in ticks. A common setup is a one-pulse-per-second line on channel 0 and a second rate on channel 1.

The interval is programmed as `prescale * period * divide - period`, so the spacing between pulse starts is `(interval + period) / period` ticks. With a 10 ns period, prescale 100 and interval 999,999,990, the output is one pulse per second. In aligned-start mode the channels stay idle until the time counter reaches a one-shot alarm value. Software sets that value to one reference period before a whole second, so the first pulse edge, and every edge after it, falls on a second boundary. The settings are copied only while the timer enable is low. Raising the enable again rearms every channel.

Top module: `fiper_gen`

## Requirements
- R1: While `rst_ni` is low, and on the clock after any edge that samples `enable_i` low, every `pulse_o` and `evt_o` bit is 0.
- R2: Let V be the interval of channel c (bits `[c*32 +: 32]` of `interval_i`) and P the reference period, with V+P a multiple of P. Then consecutive pulse rises on channel c are exactly (V+P)/P ticks apart.
- R3: Each pulse stays high for exactly `prescale_i` ticks, counted from its rise.
- R4: `evt_o[c]` is high for one clock, in the same cycle in which `pulse_o[c]` rises, and at no other time.
- R5: With `start_mode_i` = 0, the channels arm on the first tick that comes one or more clocks after `enable_i` rises, and the first pulse rises on the next tick. With a tick on every clock, the rise is seen after the third clock edge that follows the raise of enable.
- R6: With `start_mode_i` = 1, no pulse occurs until a tick on which `time_i` >= `alarm_i`. The first pulse rises on the next tick, whose time value is that arming time plus P.
- R7: The alarm test is greater-or-equal, so a time sequence that steps over the exact alarm value still arms on the first tick past it.
- R8: Interval, prescale, period and start mode are captured only on edges where `enable_i` is low. Changes made while enabled have no effect on period or width.
- R9: Lowering and raising `enable_i` rearms all channels with the settings captured while enable was low, including a new wait for the alarm in aligned-start mode.
- R10: On a clock with `tick_i` low, no pulse output changes state, so period and width are counted in ticks and not in clocks.
- R11: Each channel keeps its own period, independent of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Timer enable; low clears the channels and opens the settings for capture |
| tick_i | input | 1 | Timer tick; time advances by one reference period |
| start_mode_i | input | 1 | 1: wait for the alarm before pulsing |
| ref_period_i | input | 10 | Reference period in ns |
| prescale_i | input | 16 | Pulse width in ticks |
| interval_i | input | 64 | Per-channel intervals, channel c at bits [c*32 +: 32] |
| time_i | input | 64 | Current time counter in ns |
| alarm_i | input | 64 | Alarm compare value for the aligned start |
| pulse_o | output | 2 | Pulse lines, one per channel |
| evt_o | output | 2 | One-clock event strobe per pulse, one per channel |

## Verification
The bench uses the default sizes (two channels, 32-bit intervals, 16-bit prescale, 10-bit period, 64-bit time). It programs a 5 ns period with intervals of 55, 95 and 15 and prescale values of 4, 2 and 1, which gives periods of 12, 20 and 4 ticks. These small values let full periods, widths and back-to-back rises be measured in a few hundred cycles. An alarm at 1000 ns, reached with time stepping from 0 and from 3, brings both the exact alarm match and the skipped-over match into a short run. An alternating tick pattern shows that counting is done in ticks and not in clocks.

// File: rtl/fiper_pkg.sv
package fiper_pkg;
  typedef enum logic [1:0] {
    ARM_IDLE = 2'd0,
    ARM_WAIT = 2'd1,
    ARM_RUN  = 2'd2
  } arm_state_e;
endpackage

// File: rtl/fiper_arm.sv
module fiper_arm
  import fiper_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              tick_i,
  input  logic              smode_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [TIME_W-1:0] alarm_i,
  output logic              arm_o
);
  arm_state_e state_q;
  logic       go;

  // >= so a time step that jumps over the alarm still arms
  assign go    = tick_i && (!smode_i || (time_i >= alarm_i));
  assign arm_o = (state_q == ARM_WAIT) && go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARM_IDLE;
    end else if (!enable_i) begin
      state_q <= ARM_IDLE;
    end else begin
      case (state_q)
        ARM_IDLE: state_q <= ARM_WAIT;
        ARM_WAIT: if (go) state_q <= ARM_RUN;
        default:  state_q <= ARM_RUN;
      endcase
    end
  end
endmodule

// File: rtl/fiper_chan.sv
module fiper_chan #(
  parameter int IVL_W  = 32,
  parameter int PRSC_W = 16,
  parameter int PER_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              arm_i,
  input  logic              tick_i,
  input  logic [IVL_W-1:0]  ivl_i,
  input  logic [PRSC_W-1:0] prsc_i,
  input  logic [PER_W-1:0]  per_i,
  output logic              pulse_o,
  output logic              evt_o
);
  logic              active_q;
  logic [IVL_W-1:0]  cnt_q;
  logic [PRSC_W-1:0] wcnt_q;
  logic              pulse_q;
  logic              evt_q;
  logic [IVL_W-1:0]  per_ext;
  logic [PRSC_W-1:0] width;
  logic              fire;

  assign per_ext = IVL_W'(per_i);
  assign width   = (prsc_i == '0) ? PRSC_W'(1) : prsc_i;
  // underflow of the next decrement starts a pulse
  assign fire    = tick_i && active_q && (cnt_q < per_ext);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      wcnt_q   <= '0;
      pulse_q  <= 1'b0;
      evt_q    <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (clear_i) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
        wcnt_q   <= '0;
        pulse_q  <= 1'b0;
      end else if (arm_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (tick_i && active_q) begin
        if (fire) begin
          cnt_q   <= ivl_i;
          pulse_q <= 1'b1;
          wcnt_q  <= width;
          evt_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q - per_ext;
          if (pulse_q) begin
            if (wcnt_q <= PRSC_W'(1)) pulse_q <= 1'b0;
            else                      wcnt_q  <= wcnt_q - PRSC_W'(1);
          end
        end
      end
    end
  end

  assign pulse_o = pulse_q;
  assign evt_o   = evt_q;
endmodule

// File: rtl/fiper_gen.sv
module fiper_gen #(
  parameter int NCH    = 2,
  parameter int IVL_W  = 32,
  parameter int PRSC_W = 16,
  parameter int PER_W  = 10,
  parameter int TIME_W = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 enable_i,
  input  logic                 tick_i,
  input  logic                 start_mode_i,
  input  logic [PER_W-1:0]     ref_period_i,
  input  logic [PRSC_W-1:0]    prescale_i,
  input  logic [NCH*IVL_W-1:0] interval_i,
  input  logic [TIME_W-1:0]    time_i,
  input  logic [TIME_W-1:0]    alarm_i,
  output logic [NCH-1:0]       pulse_o,
  output logic [NCH-1:0]       evt_o
);
  localparam int IVL_TOT = NCH * IVL_W;

  logic [IVL_TOT-1:0] ivl_sh;
  logic [PRSC_W-1:0]  prsc_sh;
  logic [PER_W-1:0]   per_sh;
  logic               smode_sh;
  logic               arm;

  // settings open for capture only while the timer is disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ivl_sh   <= '0;
      prsc_sh  <= '0;
      per_sh   <= '0;
      smode_sh <= 1'b0;
    end else if (!enable_i) begin
      ivl_sh   <= interval_i;
      prsc_sh  <= prescale_i;
      per_sh   <= ref_period_i;
      smode_sh <= start_mode_i;
    end
  end

  fiper_arm #(.TIME_W(TIME_W)) u_arm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .tick_i   (tick_i),
    .smode_i  (smode_sh),
    .time_i   (time_i),
    .alarm_i  (alarm_i),
    .arm_o    (arm)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    fiper_chan #(.IVL_W(IVL_W), .PRSC_W(PRSC_W), .PER_W(PER_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (!enable_i),
      .arm_i   (arm),
      .tick_i  (tick_i),
      .ivl_i   (ivl_sh[c*IVL_W +: IVL_W]),
      .prsc_i  (prsc_sh),
      .per_i   (per_sh),
      .pulse_o (pulse_o[c]),
      .evt_o   (evt_o[c])
    );
  end
endmodule

// File: rtl/fiper_gen_chk.sv
module fiper_gen_chk #(
  parameter int NCH    = 2,
  parameter int IVL_W  = 32,
  parameter int PRSC_W = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 enable_i,
  input logic                 tick_i,
  input logic [NCH-1:0]       pulse_o,
  input logic [NCH-1:0]       evt_o,
  input logic [NCH*IVL_W-1:0] ivl_sh,
  input logic [PRSC_W-1:0]    prsc_sh
);
  // R1
  pulse_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (pulse_o == '0 && evt_o == '0));

  // R4
  evt_with_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o & ~pulse_o) == '0);

  // R10
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && enable_i) |=> $stable(pulse_o));

  // R10
  rise_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pulse_o & ~$past(pulse_o)) != '0) |-> $past(tick_i));

  // R8
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |=> ($stable(ivl_sh) && $stable(prsc_sh)));
endmodule

bind fiper_gen fiper_gen_chk #(.NCH(NCH), .IVL_W(IVL_W), .PRSC_W(PRSC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .enable_i (enable_i),
  .tick_i   (tick_i),
  .pulse_o  (pulse_o),
  .evt_o    (evt_o),
  .ivl_sh   (ivl_sh),
  .prsc_sh  (prsc_sh)
);

// File: tb/fiper_gen_tb.sv
module fiper_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        tick = 1'b1;
  logic        smode = 1'b0;
  logic [9:0]  per = 10'd5;
  logic [15:0] prsc = 16'd4;
  logic [31:0] ivl0 = 32'd55;
  logic [31:0] ivl1 = 32'd95;
  logic [63:0] tnow = '0;
  logic [63:0] alarm = '0;
  logic [1:0]  pulse, evt;

  int  checks = 0;
  int  errors = 0;
  bit  alt_tick = 1'b0;
  bit  clr = 1'b0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  fiper_gen u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .enable_i     (enable),
    .tick_i       (tick),
    .start_mode_i (smode),
    .ref_period_i (per),
    .prescale_i   (prsc),
    .interval_i   ({ivl1, ivl0}),
    .time_i       (tnow),
    .alarm_i      (alarm),
    .pulse_o      (pulse),
    .evt_o        (evt)
  );

  // monitor: inputs sampled at posedge, outputs at negedge
  logic        tick_seen = 1'b0;
  logic [63:0] time_seen = '0;
  always @(posedge clk) begin
    tick_seen <= tick;
    time_seen <= tnow;
  end

  int     tcount;
  int     nr[2], r1[2], r2[2], w1[2], ebad[2];
  longint rt1[2];
  bit     prevp[2];

  always @(negedge clk) begin
    if (clr) begin
      tcount = 0;
      for (int c = 0; c < 2; c++) begin
        nr[c] = 0; r1[c] = -1; r2[c] = -1; w1[c] = -1; ebad[c] = 0;
        rt1[c] = 0; prevp[c] = pulse[c];
      end
    end else begin
      if (tick_seen) tcount++;
      for (int c = 0; c < 2; c++) begin
        if (evt[c] != (pulse[c] && !prevp[c])) ebad[c]++;
        if (pulse[c] && !prevp[c]) begin
          nr[c]++;
          if (nr[c] == 1) begin r1[c] = tcount; rt1[c] = longint'(time_seen); end
          else if (nr[c] == 2) r2[c] = tcount;
        end
        if (!pulse[c] && prevp[c] && nr[c] >= 1 && w1[c] < 0) w1[c] = tcount - r1[c];
        prevp[c] = pulse[c];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      if (tick) tnow = tnow + 64'(per);
      tick = alt_tick ? ~tick : 1'b1;
    end
  endtask

  task automatic clear_stats();
    clr = 1'b1;
    step(1);
    clr = 1'b0;
  endtask

  task automatic t_reset();
    chk(pulse == 2'b00, "R1 reset pulse", longint'(pulse), 0);
    chk(evt == 2'b00, "R1 reset evt", longint'(evt), 0);
  endtask

  task automatic t_free();
    enable = 1'b1;
    clear_stats();
    step(80);
    chk(r1[0] == 3, "R5 first rise ch0", r1[0], 3);
    chk(r1[1] == 3, "R5 first rise ch1", r1[1], 3);
    chk(r2[0] - r1[0] == 12, "R2 period ch0", r2[0] - r1[0], 12);
    chk(r2[1] - r1[1] == 20, "R11 period ch1", r2[1] - r1[1], 20);
    chk(w1[0] == 4, "R3 width ch0", w1[0], 4);
    chk(w1[1] == 4, "R3 width ch1", w1[1], 4);
    chk(ebad[0] == 0, "R4 evt ch0", ebad[0], 0);
    chk(ebad[1] == 0, "R4 evt ch1", ebad[1], 0);
  endtask

  task automatic t_hold();
    ivl0 = 32'd15;
    prsc = 16'd1;
    clear_stats();
    step(60);
    chk(r2[0] - r1[0] == 12, "R8 period kept", r2[0] - r1[0], 12);
    chk(w1[0] == 4, "R8 width kept", w1[0], 4);
  endtask

  task automatic t_reload();
    enable = 1'b0;
    step(2);
    chk(pulse == 2'b00 && evt == 2'b00, "R1 disable clears", longint'({pulse, evt}), 0);
    enable = 1'b1;
    clear_stats();
    step(60);
    chk(r1[0] == 3, "R9 rearm first rise", r1[0], 3);
    chk(r2[0] - r1[0] == 4, "R9 new period ch0", r2[0] - r1[0], 4);
    chk(w1[0] == 1, "R9 new width ch0", w1[0], 1);
    chk(r2[1] - r1[1] == 20, "R11 period ch1", r2[1] - r1[1], 20);
  endtask

  task automatic t_align(input longint t0, input longint exp_rise, input string req);
    enable = 1'b0;
    smode = 1'b1;
    ivl0 = 32'd55;
    prsc = 16'd4;
    alarm = 64'd1000;
    step(1);
    tnow = 64'(t0);
    step(2);
    enable = 1'b1;
    clear_stats();
    step(240);
    chk(rt1[0] == exp_rise, req, rt1[0], exp_rise);
    chk(rt1[1] == exp_rise, "R6 first rise ch1", rt1[1], exp_rise);
    chk(r2[0] - r1[0] == 12, "R6 period after align", r2[0] - r1[0], 12);
  endtask

  task automatic t_gate();
    enable = 1'b0;
    smode = 1'b0;
    prsc = 16'd2;
    step(1);
    alt_tick = 1'b1;
    step(2);
    enable = 1'b1;
    clear_stats();
    step(120);
    chk(r2[0] - r1[0] == 12, "R10 period in ticks", r2[0] - r1[0], 12);
    chk(w1[0] == 2, "R10 width in ticks", w1[0], 2);
    chk(ebad[0] == 0, "R4 evt gated", ebad[0], 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_free();
    t_hold();
    t_reload();
    t_align(0, 1005, "R6 aligned rise");
    t_align(3, 1008, "R7 skipped alarm");
    t_gate();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule